// File: doc/BRIEF.md
# Multi-port digital I/O register bank

This block is a byte-addressed register file that serves 56 digital lines. Lines 0 to 23 are latched outputs that software can read back. Lines 24 to 47 are isolated inputs that can only be read. Lines 48 to 55 form an 8-bit TTL port. A control bit sets whether the TTL port drives its pins or reads them. In every register, bit n maps to line base+n.

The bus side is a synchronous 32-bit word port with four byte enables. The byte address of a register is 4*`bus_addr` + lane, and lane k occupies bits 8k+7:8k. Five bytes hold change-of-state status and enable state, and a neighbouring block implements them. This block decodes their accesses, forwards the write strobes and data, and returns their read values.

One byte is a board-reset register. Writing any value to it clears the local latches and raises a pulse that the neighbour uses. Reading it returns the level of the interrupt output pin.

Top module: `dio_regbank`

## Requirements
- R1: After `rst_n` is deasserted, `out_lines`, `ttl_out`, `ttl_oe` and `bus_rdata` are all zero, and word 0 reads as 0.
- R2: Writing bytes 0, 1 and 2 (word 0, lanes 0-2) sets `out_lines[7:0]`, `[15:8]` and `[23:16]` respectively. A read of those bytes returns the value last written.
- R3: Bytes 4, 5 and 6 (word 1, lanes 0-2) return `iso_in` after a two-flop synchronizer. A read issued in the same cycle that the pins change still returns the old value. Writes to these bytes have no effect.
- R4: Byte 7 (word 1, lane 3) returns the synchronized `ttl_in` pins. Writes to it have no effect.
- R5: Bit 1 of the control byte (byte 12, word 3 lane 0) drives `ttl_oe`. While that bit is 1, a write to byte 3 (word 0, lane 3) updates the TTL latch, which drives `ttl_out` and is read back from byte 3. The control byte reads back as written.
- R6: While control bit 1 is 0, a write to byte 3 is ignored: `ttl_out` and the byte 3 read value keep their old value. The mode used is the one in effect before a control write in the same cycle.
- R7: Only the lanes whose `bus_be` bit is set are written. Other lanes keep their contents.
- R8: The reserved byte 13 (word 3, lane 1) always reads 0, and writes to it are ignored.
- R9: A write with `bus_be[3]` set to word 3 (byte 15) asserts `board_reset` in that cycle. At the next clock edge it clears the output latches, the TTL latch and the control byte, and the board reset overrides any other write in the same cycle. A read of byte 15 returns `irq_pin` in bit 0 and 0 in bits 7:1.
- R10: A write to word 2 raises the matching bits of `cos_clr_wr` (lane k sets bit k). A write to byte 14 (word 3, lane 2) raises `cos_en_wr`. `cos_wdata` carries the bus write data. Word 2 reads return `cos_status`, and byte 14 returns `cos_enable`.
- R11: Read data is registered. It appears on `bus_rdata` one clock edge after `bus_rd` is sampled high, and it holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word address (4 bytes per word) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables, bit k for lane k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| out_lines | output | 24 | Output latches, lines 0-23 |
| iso_in | input | 24 | Isolated input pins, lines 24-47 |
| ttl_in | input | 8 | TTL pin levels, lines 48-55 |
| ttl_out | output | 8 | TTL output latch |
| ttl_oe | output | 1 | TTL output enable (control bit 1) |
| irq_pin | input | 1 | Level of the interrupt output pin |
| board_reset | output | 1 | Board-reset pulse for the neighbour block |
| cos_clr_wr | output | 4 | Per-byte write strobes for the change-of-state status bytes |
| cos_en_wr | output | 1 | Write strobe for the change-of-state enable byte |
| cos_wdata | output | 32 | Write data forwarded to the neighbour block |
| cos_status | input | 32 | Change-of-state status read value |
| cos_enable | input | 8 | Change-of-state enable read value |

## Verification
The output bytes are written with distinct values in each lane, and then with a single-lane partial write. This shows whether the lanes are swapped and whether the byte enables are honoured. The input bytes are read with two different pin patterns and once in the same cycle as a pin change, which exposes a missing or shortened synchronizer. The TTL latch is written in input mode and again in output mode, before and after a board reset, to show whether the mode gating works and whether the reset clears the latches. Fixed external values on the change-of-state inputs and on `irq_pin` check the lane placement of the forwarded bytes and of the reset register's read value.

// File: rtl/dio_regbank.sv
module dio_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [23:0] out_lines,
  input  logic [23:0] iso_in,
  input  logic [7:0]  ttl_in,
  output logic [7:0]  ttl_out,
  output logic        ttl_oe,
  input  logic        irq_pin,
  output logic        board_reset,
  output logic [3:0]  cos_clr_wr,
  output logic        cos_en_wr,
  output logic [31:0] cos_wdata,
  input  logic [31:0] cos_status,
  input  logic [7:0]  cos_enable
);

  logic [23:0] out_q;
  logic [7:0]  ttl_q;
  logic [7:0]  ctl_q;
  logic [23:0] iso_s1, iso_s2;
  logic [7:0]  ttl_s1, ttl_s2;
  logic [31:0] rd_word;

  wire wr_w0 = bus_wr && (bus_addr == 2'd0);
  wire wr_w2 = bus_wr && (bus_addr == 2'd2);
  wire wr_w3 = bus_wr && (bus_addr == 2'd3);

  assign board_reset = wr_w3 && bus_be[3];
  assign cos_clr_wr  = {4{wr_w2}} & bus_be;
  assign cos_en_wr   = wr_w3 && bus_be[2];
  assign cos_wdata   = bus_wdata;

  assign out_lines = out_q;
  assign ttl_out   = ttl_q;
  assign ttl_oe    = ctl_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n || board_reset) begin
      out_q <= '0;
      ttl_q <= '0;
      ctl_q <= '0;
    end else begin
      for (int i = 0; i < 3; i++)
        if (wr_w0 && bus_be[i]) out_q[8*i +: 8] <= bus_wdata[8*i +: 8];
      if (wr_w0 && bus_be[3] && ctl_q[1]) ttl_q <= bus_wdata[31:24];
      if (wr_w3 && bus_be[0]) ctl_q <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iso_s1 <= '0;
      iso_s2 <= '0;
      ttl_s1 <= '0;
      ttl_s2 <= '0;
    end else begin
      iso_s1 <= iso_in;
      iso_s2 <= iso_s1;
      ttl_s1 <= ttl_in;
      ttl_s2 <= ttl_s1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    rd_word = {ttl_q, out_q};
      2'd1:    rd_word = {ttl_s2, iso_s2};
      2'd2:    rd_word = cos_status;
      default: rd_word = {7'b0, irq_pin, cos_enable, 8'h00, ctl_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

endmodule

// File: rtl/dio_regbank_chk.sv
module dio_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [23:0] out_lines,
  input logic [7:0]  ttl_out,
  input logic        ttl_oe,
  input logic [3:0]  cos_clr_wr
);

  p_out_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_be[0]) |=> out_lines[7:0] == $past(bus_wdata[7:0]));

  p_ttl_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_be[3] && !ttl_oe) |=> $stable(ttl_out));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |=> bus_rdata[15:8] == 8'h00);

  p_board_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && bus_be[3]) |=> (out_lines == '0 && ttl_out == '0 && !ttl_oe));

  p_cos_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cos_clr_wr != 4'b0) |-> (bus_wr && bus_addr == 2'd2));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind dio_regbank dio_regbank_chk i_chk (.*);

// File: tb/test_dio_regbank.sv
`timescale 1ns/1ps
module test_dio_regbank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [23:0] out_lines;
  logic [23:0] iso_in = 0;
  logic [7:0]  ttl_in = 0;
  logic [7:0]  ttl_out;
  logic        ttl_oe;
  logic        irq_pin = 0;
  logic        board_reset;
  logic [3:0]  cos_clr_wr;
  logic        cos_en_wr;
  logic [31:0] cos_wdata;
  logic [31:0] cos_status = 0;
  logic [7:0]  cos_enable = 0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  always #2.5 clk = ~clk;

  dio_regbank i_dio_regbank (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_be = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_lines", {8'h0, out_lines}, 0);
    check("R1 ttl_oe", {31'h0, ttl_oe}, 0);
    check("R1 ttl_out", {24'h0, ttl_out}, 0);
    check("R1 rdata", bus_rdata, 0);
    rd(2'd0, 32'h0, "R1 word0");

    wr(2'd0, 4'b1111, 32'hFFA55A3C);
    check("R2 out_lines", {8'h0, out_lines}, 32'h00A55A3C);
    check("R6 ttl_out input mode", {24'h0, ttl_out}, 0);
    rd(2'd0, 32'h00A55A3C, "R2 R6 word0 readback");

    wr(2'd0, 4'b0010, 32'h11223344);
    check("R7 out_lines partial", {8'h0, out_lines}, 32'h00A5333C);
    rd(2'd0, 32'h00A5333C, "R7 word0 readback");

    iso_in = 24'h123456; ttl_in = 8'h9B;
    repeat (3) @(negedge clk);
    rd(2'd1, 32'h9B123456, "R3 R4 inputs pattern A");
    wr(2'd1, 4'b1111, 32'hFFFFFFFF);
    rd(2'd1, 32'h9B123456, "R3 R4 write ignored");

    @(negedge clk);
    iso_in = 24'hFEDCBA; ttl_in = 8'h01;
    bus_addr = 2'd1; bus_rd = 1;
    exp_q.push_back(32'h9B123456); tag_q.push_back("R3 sync delay old value");
    @(negedge clk);
    bus_rd = 0;
    rd(2'd1, 32'h01FEDCBA, "R3 R4 inputs pattern B");

    wr(2'd3, 4'b0001, 32'h00000002);
    check("R5 ttl_oe", {31'h0, ttl_oe}, 1);
    wr(2'd0, 4'b1000, 32'hC3000000);
    check("R5 ttl_out", {24'h0, ttl_out}, 32'hC3);
    rd(2'd0, 32'hC3A5333C, "R5 ttl latch readback");

    wr(2'd3, 4'b0010, 32'h0000FF00);
    cos_status = 32'hDEADBEEF; cos_enable = 8'h5A; irq_pin = 1;
    rd(2'd3, 32'h015A0002, "R5 R8 R9 R10 word3");
    rd(2'd2, 32'hDEADBEEF, "R10 status read");

    @(negedge clk);
    bus_addr = 2'd2; bus_be = 4'b0101; bus_wdata = 32'h0F0F0F0F; bus_wr = 1;
    #1;
    check("R10 cos_clr_wr", {28'h0, cos_clr_wr}, 32'h5);
    check("R10 cos_wdata", cos_wdata, 32'h0F0F0F0F);
    @(negedge clk);
    bus_addr = 2'd3; bus_be = 4'b0100;
    #1;
    check("R10 cos_en_wr", {31'h0, cos_en_wr}, 1);
    check("R10 no status strobe", {28'h0, cos_clr_wr}, 0);
    @(negedge clk);
    bus_wr = 0; bus_be = 0;

    @(negedge clk);
    bus_addr = 2'd3; bus_be = 4'b1001; bus_wdata = 32'h00000002; bus_wr = 1;
    #1;
    check("R9 board_reset pulse", {31'h0, board_reset}, 1);
    @(negedge clk);
    bus_wr = 0; bus_be = 0;
    check("R9 out cleared", {8'h0, out_lines}, 0);
    check("R9 ttl cleared", {24'h0, ttl_out}, 0);
    check("R9 oe cleared", {31'h0, ttl_oe}, 0);
    rd(2'd0, 32'h0, "R9 word0 cleared");
    rd(2'd3, 32'h015A0000, "R9 irq high");
    irq_pin = 0;
    rd(2'd3, 32'h005A0000, "R9 irq low");

    wr(2'd0, 4'b1000, 32'h77000000);
    check("R6 ttl after reset", {24'h0, ttl_out}, 0);
    rd(2'd0, 32'h0, "R6 latch read");

    iso_in = 24'h0;
    repeat (4) @(negedge clk);
    check("R11 rdata hold", bus_rdata, 32'h0);
    rd(2'd1, 32'h01000000, "R11 latency");
    repeat (2) @(negedge clk);
    check("R11 hold after read", bus_rdata, 32'h01000000);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule